// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when the backup battery is measured and keeps the result as a sticky status bit. A measurement runs once whenever main power comes up. While power stays at its nominal level, a measurement then runs once every fixed interval of one-second ticks. The default interval is 86400 ticks, which is one day. No measurement starts, and none finishes, while the main supply is below nominal.

Each measurement begins with a one-cycle strobe to an external comparator. The block then waits a fixed number of settling cycles and samples the comparator's verdict. The battery-low bit takes that verdict. It is never cleared by anything except a later measurement that finds the battery good. A second bit records which kind of check produced the most recent failure. A failure at power-up means stored data may already be suspect. A failure on the daily check means the battery is nearing the end of its life. The status bit is also presented inside an 8-bit flags image for the register file.

Top module: `batt_low_monitor`

## Requirements
- R1: After reset, `batt_low`, `low_from_pwrup` and `sample_req` are 0 and `flags_byte` is 8'h00.
- R2: A `pwrup_pulse` seen at a clock edge while `supply_ok` is 1 raises `sample_req` for exactly one cycle, starting right after that edge.
- R3: The comparator input `batt_below` (1 = battery under threshold) is sampled at the clock edge that comes `SETTLE_CYCLES` edges after the edge that raised `sample_req`. `batt_low` takes that value right after the sampling edge and not before it.
- R4: `batt_low` changes only when a check completes. Once set, it stays set through any change of `batt_below` until a later check samples 0.
- R5: A periodic check, with its own `sample_req` strobe, is issued on the `TICKS_PER_CHECK`-th `sec_tick` counted since the last power-up check or periodic check. No check is issued on any earlier tick.
- R6: `sec_tick` pulses are not counted while `supply_ok` is 0. The count held at that moment resumes when the supply returns.
- R7: While `supply_ok` is 0, no check starts and `pwrup_pulse` is ignored. A check still in flight when the supply drops is abandoned and leaves `batt_low` unchanged.
- R8: A power-up check restarts the interval count from zero.
- R9: A failing check sets `low_from_pwrup` to 1 if it was a power-up check and to 0 if it was a periodic check. A passing check leaves `low_from_pwrup` unchanged.
- R10: `flags_byte` carries `batt_low` at bit 4. All other bits of `flags_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Main supply is at nominal level |
| pwrup_pulse | input | 1 | One-cycle event marking a power-up |
| sec_tick | input | 1 | One-cycle pulse once per second |
| batt_below | input | 1 | Comparator verdict, 1 = battery below threshold |
| sample_req | output | 1 | One-cycle measurement strobe to the comparator |
| batt_low | output | 1 | Sticky battery-low status |
| low_from_pwrup | output | 1 | Last failure came from a power-up check |
| flags_byte | output | 8 | Flags image with `batt_low` at bit 4 |

## Verification
The hardest situation to reach from the ports is a supply loss in the middle of the day-long interval, followed by a return of the supply. The count must freeze and then resume from the same value, with no stray strobe and no reload. The bench scales the interval down to 20 ticks. It counts ticks since the last check, drops the supply after 5 ticks, and delivers many more ticks plus a power-up pulse while the supply is low. It then restores the supply and shows that the strobe appears exactly on the 20th tick counted while powered. A second hard case, a check abandoned during settling, is reached by dropping the supply the cycle after the strobe.

// File: rtl/batmon_pkg.sv
package batmon_pkg;

  localparam int unsigned BATT_LOW_BIT = 4;

  typedef enum logic {
    ST_IDLE,
    ST_SETTLE
  } seq_state_e;

  // True when a counter sits on the final value of a limit-long run.
  function automatic logic at_limit(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction

  // Place the battery-low status at its bit in the flags image.
  function automatic logic [7:0] flags_image(input logic low);
    logic [7:0] img;
    img = '0;
    img[BATT_LOW_BIT] = low;
    return img;
  endfunction

endpackage

// File: rtl/batmon_interval.sv
module batmon_interval #(
  parameter int unsigned TICKS_PER_CHECK = 86400,
  parameter int unsigned CW = $clog2(TICKS_PER_CHECK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          restart,
  input  logic          sec_tick,
  output logic          due,
  output logic [CW-1:0] count
);
  import batmon_pkg::*;

  logic counting;
  assign counting = supply_ok && sec_tick;
  assign due      = counting && at_limit(32'(count), TICKS_PER_CHECK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (counting) begin
      if (due) count <= '0;
      else     count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/batmon_seq.sv
module batmon_seq #(
  parameter int unsigned SETTLE_CYCLES = 8,
  parameter int unsigned WW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic start_pwrup,
  input  logic start_periodic,
  input  logic batt_below,
  output logic sample_req,
  output logic capture_evt,
  output logic chk_src_pwrup,
  output logic batt_low,
  output logic low_from_pwrup
);
  import batmon_pkg::*;

  seq_state_e    state;
  logic [WW-1:0] wait_cnt;
  logic          launch;

  assign launch      = start_pwrup || (state == ST_IDLE && start_periodic);
  assign capture_evt = (state == ST_SETTLE) && supply_ok && !start_pwrup
                       && at_limit(32'(wait_cnt), SETTLE_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      wait_cnt       <= '0;
      sample_req     <= 1'b0;
      chk_src_pwrup  <= 1'b0;
      batt_low       <= 1'b0;
      low_from_pwrup <= 1'b0;
    end else if (!supply_ok) begin
      state      <= ST_IDLE;
      sample_req <= 1'b0;
    end else if (launch) begin
      state         <= ST_SETTLE;
      wait_cnt      <= '0;
      sample_req    <= 1'b1;
      chk_src_pwrup <= start_pwrup;
    end else begin
      sample_req <= 1'b0;
      if (capture_evt) begin
        state    <= ST_IDLE;
        batt_low <= batt_below;
        if (batt_below) low_from_pwrup <= chk_src_pwrup;
      end else if (state == ST_SETTLE) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/batt_low_monitor.sv
module batt_low_monitor #(
  parameter int unsigned TICKS_PER_CHECK = 86400,
  parameter int unsigned SETTLE_CYCLES   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pwrup_pulse,
  input  logic       sec_tick,
  input  logic       batt_below,
  output logic       sample_req,
  output logic       batt_low,
  output logic       low_from_pwrup,
  output logic [7:0] flags_byte
);
  import batmon_pkg::*;

  localparam int unsigned CW = $clog2(TICKS_PER_CHECK);

  logic          start_pwrup;
  logic          periodic_due;
  logic          capture_evt;
  logic          chk_src_pwrup;
  logic [CW-1:0] tick_count;

  assign start_pwrup = supply_ok && pwrup_pulse;

  batmon_interval #(
    .TICKS_PER_CHECK(TICKS_PER_CHECK),
    .CW(CW)
  ) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .restart  (start_pwrup),
    .sec_tick (sec_tick),
    .due      (periodic_due),
    .count    (tick_count)
  );

  batmon_seq #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .start_pwrup   (start_pwrup),
    .start_periodic(periodic_due),
    .batt_below    (batt_below),
    .sample_req    (sample_req),
    .capture_evt   (capture_evt),
    .chk_src_pwrup (chk_src_pwrup),
    .batt_low      (batt_low),
    .low_from_pwrup(low_from_pwrup)
  );

  assign flags_byte = flags_image(batt_low);

endmodule

// File: rtl/batmon_chk.sv
module batmon_chk #(
  parameter int unsigned TICKS_PER_CHECK = 86400,
  parameter int unsigned CW = $clog2(TICKS_PER_CHECK)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          pwrup_pulse,
  input logic          batt_below,
  input logic          sample_req,
  input logic          batt_low,
  input logic          low_from_pwrup,
  input logic          capture_evt,
  input logic          chk_src_pwrup,
  input logic [CW-1:0] tick_count
);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |=> !sample_req); // R2

  AST_REQ_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> $past(supply_ok)); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> $stable(batt_low)); // R4

  AST_FLAG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (batt_low == $past(batt_below))); // R3

  AST_QUAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_evt && batt_below) |=> (low_from_pwrup == $past(chk_src_pwrup))); // R9

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tick_count < CW'(TICKS_PER_CHECK)); // R5

  AST_PWRUP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && pwrup_pulse) |=> (tick_count == '0 && sample_req)); // R8

endmodule

bind batt_low_monitor batmon_chk #(
  .TICKS_PER_CHECK(TICKS_PER_CHECK)
) u_batmon_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok     (supply_ok),
  .pwrup_pulse   (pwrup_pulse),
  .batt_below    (batt_below),
  .sample_req    (sample_req),
  .batt_low      (batt_low),
  .low_from_pwrup(low_from_pwrup),
  .capture_evt   (capture_evt),
  .chk_src_pwrup (chk_src_pwrup),
  .tick_count    (tick_count)
);

// File: tb/tb_batt_low_monitor.sv
module tb_batt_low_monitor;
  localparam int unsigned TICKS  = 20;
  localparam int unsigned SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       pwrup_pulse = 1'b0;
  logic       sec_tick = 1'b0;
  logic       batt_below = 1'b0;
  logic       sample_req;
  logic       batt_low;
  logic       low_from_pwrup;
  logic [7:0] flags_byte;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  batt_low_monitor #(
    .TICKS_PER_CHECK(TICKS),
    .SETTLE_CYCLES(SETTLE)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .pwrup_pulse   (pwrup_pulse),
    .sec_tick      (sec_tick),
    .batt_below    (batt_below),
    .sample_req    (sample_req),
    .batt_low      (batt_low),
    .low_from_pwrup(low_from_pwrup),
    .flags_byte    (flags_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Ends at the negedge right after the edge that sees the pulse.
  task automatic pulse_pwrup();
    @(negedge clk) pwrup_pulse = 1'b1;
    @(negedge clk) pwrup_pulse = 1'b0;
  endtask

  // Sends n ticks and counts strobes seen; ends one negedge after the last tick's edge.
  task automatic ticks(input int n, output int reqs);
    reqs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      if (sample_req) reqs++;
    end
  endtask

  // Called at the negedge just after the launching edge.
  task automatic expect_check(input string req, input logic old_low, input logic new_low);
    check({req, " strobe high"}, sample_req, 1'b1);
    @(negedge clk);
    check({req, " strobe one cycle (R2)"}, sample_req, 1'b0);
    repeat (SETTLE - 2) @(negedge clk);
    check({req, " flag not early (R3)"}, batt_low, old_low);
    @(negedge clk);
    check({req, " flag after settle (R3)"}, batt_low, new_low);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 batt_low", batt_low, 1'b0);
    check("R1 qualifier", low_from_pwrup, 1'b0);
    check("R1 strobe", sample_req, 1'b0);
    check("R1 flags", flags_byte, 8'h00);
  endtask

  task automatic t_pwrup_fail();
    batt_below = 1'b1;
    pulse_pwrup();
    expect_check("R2 pwrup", 1'b0, 1'b1);
    check("R9 pwrup fail source", low_from_pwrup, 1'b1);
    check("R10 flags bit4", flags_byte, 8'h10);
  endtask

  task automatic t_sticky();
    batt_below = 1'b0;
    repeat (12) @(negedge clk);
    check("R4 sticky without check", batt_low, 1'b1);
    check("R4 no strobe", sample_req, 1'b0);
  endtask

  task automatic t_periodic_pass();
    int r;
    batt_below = 1'b0;
    ticks(TICKS - 1, r);
    check("R5 no early periodic strobe", r, 0);
    ticks(1, r);
    expect_check("R5 periodic", 1'b1, 1'b0);
    check("R9 pass keeps qualifier", low_from_pwrup, 1'b1);
    check("R10 flags clear", flags_byte, 8'h00);
  endtask

  task automatic t_periodic_fail();
    int r;
    batt_below = 1'b1;
    ticks(TICKS - 1, r);
    check("R5 no early strobe after wrap", r, 0);
    ticks(1, r);
    expect_check("R5 periodic fail", 1'b0, 1'b1);
    check("R9 periodic fail source", low_from_pwrup, 1'b0);
  endtask

  task automatic t_pwrup_restarts_count();
    int r;
    batt_below = 1'b0;
    ticks(7, r);
    pulse_pwrup();
    expect_check("R8 pwrup pass", 1'b1, 1'b0);
    check("R9 qualifier kept on pass", low_from_pwrup, 1'b0);
    ticks(TICKS - 1, r);
    check("R8 count restarted", r, 0);
    ticks(1, r);
    expect_check("R8 due after full interval", 1'b0, 1'b0);
  endtask

  task automatic t_supply_hold();
    int r;
    int tot;
    batt_below = 1'b1;
    ticks(5, r);
    tot = r;
    @(negedge clk) supply_ok = 1'b0;
    ticks(3 * TICKS, r);
    tot += r;
    pulse_pwrup();
    check("R7 pwrup ignored without supply", sample_req, 1'b0);
    repeat (SETTLE + 2) @(negedge clk);
    check("R7 flag untouched without supply", batt_low, 1'b0);
    @(negedge clk) supply_ok = 1'b1;
    ticks(TICKS - 6, r);
    tot += r;
    check("R6 no strobe while held", tot, 0);
    ticks(1, r);
    expect_check("R6 resumed count", 1'b0, 1'b1);
    check("R9 periodic after hold", low_from_pwrup, 1'b0);
  endtask

  task automatic t_abort();
    batt_below = 1'b0;
    pulse_pwrup();
    check("R2 strobe before abort", sample_req, 1'b1);
    supply_ok = 1'b0;
    repeat (SETTLE + 4) @(negedge clk);
    check("R7 aborted check leaves flag", batt_low, 1'b1);
    check("R7 aborted qualifier", low_from_pwrup, 1'b0);
    supply_ok = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    supply_ok = 1'b1;
    t_pwrup_fail();
    t_sticky();
    t_periodic_pass();
    t_periodic_fail();
    t_pwrup_restarts_count();
    t_supply_hold();
    t_abort();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule